// File: doc/BRIEF.md
# Bulk Erase Sequencer

This block is the host-side controller for a whole-chip erase of a byte-wide flash part. It owns the part's programming-voltage enable and one simple command/read bus port. After a launch it raises the voltage enable and lets the supply settle. It then writes the erase opcode 20h twice in a row. The first write arms the erase and the second one fires it. The block holds off for one erase-pulse time and then walks the array byte by byte. For each byte it writes the verify opcode A0h with that byte's address, waits a recovery time, reads the byte back and expects FFh.

A byte that reads back anything other than FFh costs one erase pulse from a single budget shared by the whole run. The chip is erased again, and the walk picks up at the same byte rather than at address zero. Once the top address passes, the block writes FFh to put the part back into read mode and drops the voltage enable. If the shared budget runs out first, it drops the enable and flags an error, reporting the byte that stopped it. The launch is refused unless the caller asserts that the whole array already holds 00h.

States:
- `IDLE`: after reset.
- `SETTLE`: voltage up, timed.
- `ARM`: first 20h write.
- `FIRE`: second 20h write.
- `PULSE`: timed erase pulse.
- `VERIFY`: A0h write with the address.
- `RECOVER`: timed.
- `CHECK`: read and compare.
- `RESTORE`: FFh write.
- `FINISH`: success, holding.
- `ABORT`: error, holding.

Transitions:
- Launch: `IDLE`/`FINISH`/`ABORT` to `SETTLE`.
- Settle expiry: to `ARM`.
- Acknowledge: `ARM` to `FIRE`, `FIRE` to `PULSE`, `VERIFY` to `RECOVER`, `RESTORE` to `FINISH`.
- Pulse expiry: to `VERIFY`.
- Recovery expiry: to `CHECK`.
- From `CHECK`:
  - A pass on a non-top address goes to `VERIFY` at the next address.
  - A pass on the top address goes to `RESTORE`.
  - A miss goes to `ARM` with the address kept.
  - A miss that exhausts the budget goes to `ABORT`.

Top module: `erase_seq`

## Requirements
- R1: After reset, `hv_en`, `bus_req`, `done` and `err` are all 0.
- R2: A `start` pulse while `preprog_ok` is 0 has no effect: `hv_en` and `bus_req` stay 0, and a held `done` stays 1.
- R3: `hv_en` is 1 during every bus request, and the first request of a run comes at least `SETTLE_CYC` cycles after `hv_en` rises.
- R4: Every erase is two back-to-back write transactions of data 20h, with no other transaction between them.
- R5: At least `PULSE_CYC` cycles pass between the acknowledge of the second 20h write and the next verify write.
- R6: The verify write carries data A0h and the address under test. The first verify of a run uses address 0, and after each pass the next verify uses the next higher address.
- R7: After each verify write at least `RECOV_CYC` cycles pass, then a read of the same address follows.
- R8: A read returning FFh passes the byte. Any other value adds one to the pulse count and starts a new 20h/20h erase, after which verification resumes at the failing address.
- R9: After the top address (all ones) passes, exactly one write of data FFh follows. Then `hv_en` falls and `done` rises.
- R10: When the failure count reaches `MAX_PULSES`, no further erase is issued. `hv_en` falls, `err` rises and `fail_addr` holds the failing address.
- R11: A request keeps `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ack`, and each acknowledge completes exactly one transaction.
- R12: `done` and `err` are mutually exclusive and hold until the next accepted launch, which clears them on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | launch strobe |
| preprog_ok | input | 1 | caller asserts the array holds all 00h |
| hv_en | output | 1 | programming-voltage enable |
| bus_req | output | 1 | transaction request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | byte address |
| bus_wdata | output | 8 | write data (opcode) |
| bus_ack | input | 1 | one-cycle transaction acknowledge |
| bus_rdata | input | 8 | read data, valid with `bus_ack` on a read |
| done | output | 1 | erase completed |
| err | output | 1 | pulse budget exhausted |
| fail_addr | output | ADDR_W | address of the most recent failed byte |

## Verification
A launch shows on `hv_en` one cycle after the edge that samples it. Each timed state lasts exactly its parameter in cycles, so the timing checks compare the cycle gaps between bus events against those parameters as lower bounds; bus acknowledges come after a random delay. Each transaction is checked at the falling edge on which it is acknowledged, against a bench array model that needs a chosen number of pulses per byte. The final flags, the pulse count, the verify count and the fail address are compared once `done` or `err` has risen, using outcomes computed from the per-byte pulse needs.

// File: rtl/es_pkg.sv
package es_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_SETTLE, S_ARM, S_FIRE, S_PULSE, S_VERIFY,
        S_RECOVER, S_CHECK, S_RESTORE, S_FINISH, S_ABORT
    } es_state_t;

    localparam logic [7:0] OP_ERASE  = 8'h20;
    localparam logic [7:0] OP_VERIFY = 8'hA0;
    localparam logic [7:0] OP_READ   = 8'hFF;
    localparam logic [7:0] BYTE_BLANK = 8'hFF;
endpackage

// File: rtl/es_timer.sv
module es_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == limit - 1'b1);
endmodule

// File: rtl/es_addr_walk.sv
module es_addr_walk #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_top
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) addr <= '0;
        else if (step)     addr <= addr + 1'b1;
    end

    assign at_top = &addr;
endmodule

// File: rtl/es_pulse_count.sv
module es_pulse_count #(
    parameter int MAX_PULSES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic at_limit
);
    localparam int PC_W = $clog2(MAX_PULSES + 1);
    logic [PC_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (bump)     cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == PC_W'(MAX_PULSES - 1));
endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import es_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int SETTLE_CYC = 100,
    parameter int PULSE_CYC  = 500000,
    parameter int RECOV_CYC  = 300,
    parameter int MAX_PULSES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              preprog_ok,
    output logic              hv_en,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int TMR_MAX_A = (SETTLE_CYC > RECOV_CYC) ? SETTLE_CYC : RECOV_CYC;
    localparam int TMR_MAX   = (PULSE_CYC > TMR_MAX_A) ? PULSE_CYC : TMR_MAX_A;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);

    es_state_t st, nxt;
    logic [TMR_W-1:0]  tmr_limit;
    logic [ADDR_W-1:0] cur_addr;
    logic tmr_run, tmr_exp, at_top, at_limit;
    logic resting, launch, pass, step, bump;

    assign resting = (st == S_IDLE) || (st == S_FINISH) || (st == S_ABORT);
    assign launch  = resting && start && preprog_ok;
    assign pass    = (bus_rdata == BYTE_BLANK);
    assign step    = (st == S_CHECK) && bus_ack && pass && !at_top;
    assign bump    = (st == S_CHECK) && bus_ack && !pass;
    assign tmr_run = (st == S_SETTLE) || (st == S_PULSE) || (st == S_RECOVER);

    always_comb begin
        unique case (st)
            S_PULSE:   tmr_limit = TMR_W'(PULSE_CYC);
            S_RECOVER: tmr_limit = TMR_W'(RECOV_CYC);
            default:   tmr_limit = TMR_W'(SETTLE_CYC);
        endcase
    end

    es_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run),
        .limit(tmr_limit), .expired(tmr_exp)
    );

    es_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(launch), .step(step),
        .addr(cur_addr), .at_top(at_top)
    );

    es_pulse_count #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
        .clk(clk), .rst_n(rst_n), .clr(launch), .bump(bump),
        .at_limit(at_limit)
    );

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE, S_FINISH, S_ABORT: if (launch) nxt = S_SETTLE;
            S_SETTLE:  if (tmr_exp) nxt = S_ARM;
            S_ARM:     if (bus_ack) nxt = S_FIRE;
            S_FIRE:    if (bus_ack) nxt = S_PULSE;
            S_PULSE:   if (tmr_exp) nxt = S_VERIFY;
            S_VERIFY:  if (bus_ack) nxt = S_RECOVER;
            S_RECOVER: if (tmr_exp) nxt = S_CHECK;
            S_CHECK: begin
                if (bus_ack) begin
                    if (pass) nxt = at_top ? S_RESTORE : S_VERIFY;
                    else      nxt = at_limit ? S_ABORT : S_ARM;
                end
            end
            S_RESTORE: if (bus_ack) nxt = S_FINISH;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            fail_addr <= '0;
        end else begin
            st <= nxt;
            if (launch)    fail_addr <= '0;
            else if (bump) fail_addr <= cur_addr;
        end
    end

    always_comb begin
        hv_en     = !resting;
        bus_req   = 1'b0;
        bus_we    = 1'b1;
        bus_addr  = '0;
        bus_wdata = 8'h00;
        done      = (st == S_FINISH);
        err       = (st == S_ABORT);
        unique case (st)
            S_ARM, S_FIRE: begin
                bus_req   = 1'b1;
                bus_wdata = OP_ERASE;
            end
            S_VERIFY: begin
                bus_req   = 1'b1;
                bus_addr  = cur_addr;
                bus_wdata = OP_VERIFY;
            end
            S_CHECK: begin
                bus_req  = 1'b1;
                bus_we   = 1'b0;
                bus_addr = cur_addr;
            end
            S_RESTORE: begin
                bus_req   = 1'b1;
                bus_wdata = OP_READ;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/es_checks.sv
module es_checks #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hv_en,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack,
    input logic [7:0]        bus_rdata,
    input logic              done,
    input logic              err
);
    AST_BUS_UNDER_HV: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> hv_en); // R3

    AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                                   && $stable(bus_wdata))); // R11

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R12

    AST_HV_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !hv_en); // R9

    AST_ERR_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(bus_ack) && !$past(bus_we)
                        && $past(bus_rdata) != 8'hFF)); // R10

    AST_DONE_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(bus_ack) && $past(bus_we)
                         && $past(bus_wdata) == 8'hFF)); // R9
endmodule

bind erase_seq es_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .err(err)
);

// File: tb/sim_erase_seq.sv
module sim_erase_seq;
    localparam int AW = 4;
    localparam int NB = 1 << AW;
    localparam int SETTLE = 8;
    localparam int PULSE = 20;
    localparam int RECOV = 5;
    localparam int MAXP = 6;

    logic clk = 0, rst_n = 0, start = 0, preprog_ok = 0;
    logic hv_en, bus_req, bus_we, done, err;
    logic [AW-1:0] bus_addr, fail_addr;
    logic [7:0] bus_wdata;
    logic bus_ack = 0;
    logic [7:0] bus_rdata = 8'h00;

    erase_seq #(.ADDR_W(AW), .SETTLE_CYC(SETTLE), .PULSE_CYC(PULSE),
                .RECOV_CYC(RECOV), .MAX_PULSES(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .preprog_ok(preprog_ok),
        .hv_en(hv_en), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .err(err), .fail_addr(fail_addr)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int need [NB];
    int errs = 0, checks = 0;

    // array model and protocol monitor
    int m_errs = 0, m_checks = 0;
    int pulses, verifies, restores, resume_a, last_pass, cur_a, first_ver;
    int t_hv, t_fire, t_ver, lat;
    bit hv_prev, armed, after_erase, first_req;

    task automatic mfail(string req, int act, int exp);
        m_errs++;
        $display("FAIL %s model: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    endtask

    initial begin
        pulses = 0; verifies = 0; restores = 0; resume_a = 0; last_pass = -1;
        cur_a = 0; first_ver = -1; t_hv = 0; t_fire = 0; t_ver = 0; lat = 0;
        hv_prev = 0; armed = 0; after_erase = 0; first_req = 1;
    end

    always @(negedge clk) begin
        if (start && preprog_ok && !hv_en) begin
            pulses = 0; verifies = 0; restores = 0; resume_a = 0; last_pass = -1;
            armed = 0; after_erase = 0; first_req = 1; first_ver = -1;
        end
        if (hv_en && !hv_prev) t_hv = cyc;
        hv_prev = hv_en;
        if (bus_ack) begin
            bus_ack = 0;
        end else if (bus_req) begin
            if (!hv_en) mfail("R3", 0, 1);
            if (first_req) begin
                m_checks++;
                if (cyc - t_hv < SETTLE) mfail("R3", cyc - t_hv, SETTLE);
                first_req = 0;
            end
            if (lat > 0) lat--;
            else begin
                m_checks++;
                if (bus_we && bus_wdata == 8'h20) begin
                    if (armed) begin
                        armed = 0; pulses++; after_erase = 1; t_fire = cyc;
                    end else armed = 1;
                end else if (armed) begin
                    mfail("R4", int'(bus_wdata), 32'h20);
                    armed = 0;
                end else if (bus_we && bus_wdata == 8'hA0) begin
                    if (after_erase) begin
                        if (cyc - t_fire < PULSE) mfail("R5", cyc - t_fire, PULSE);
                        if (int'(bus_addr) != resume_a) mfail("R8", int'(bus_addr), resume_a);
                        after_erase = 0;
                    end else if (int'(bus_addr) != last_pass + 1)
                        mfail("R6", int'(bus_addr), last_pass + 1);
                    if (first_ver < 0) first_ver = int'(bus_addr);
                    cur_a = int'(bus_addr); t_ver = cyc; verifies++;
                end else if (!bus_we) begin
                    if (int'(bus_addr) != cur_a) mfail("R7", int'(bus_addr), cur_a);
                    if (cyc - t_ver < RECOV) mfail("R7", cyc - t_ver, RECOV);
                    if (pulses >= need[int'(bus_addr)]) begin
                        bus_rdata = 8'hFF; last_pass = int'(bus_addr);
                    end else begin
                        bus_rdata = 8'h00; resume_a = int'(bus_addr);
                    end
                end else if (bus_we && bus_wdata == 8'hFF) begin
                    restores++;
                    if (last_pass != NB - 1) mfail("R9", last_pass, NB - 1);
                end else mfail("R11", int'(bus_wdata), 0);
                bus_ack = 1;
                lat = $urandom_range(0, 2);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch();
        @(posedge clk); #2;
        start = 1; preprog_ok = 1;
        @(posedge clk); #2;
        start = 0;
    endtask

    // expected outcome from the per-byte pulse needs
    task automatic expect_run(output bit ok, output int ep, output int ev, output int ea);
        int mx;
        mx = 0;
        for (int a = 0; a < NB; a++) if (need[a] > mx) mx = need[a];
        if (mx <= MAXP) begin
            ok = 1; ep = mx; ev = NB + mx - 1; ea = 0;
        end else begin
            ok = 0; ep = MAXP; ea = 0;
            for (int a = NB - 1; a >= 0; a--) if (need[a] > MAXP) ea = a;
            ev = ea + MAXP;
        end
    endtask

    task automatic run_case(string name);
        bit ok; int ep, ev, ea, n;
        expect_run(ok, ep, ev, ea);
        launch();
        @(negedge clk);
        chk("R12 flags cleared by launch", int'(done || err), 0);
        n = 0;
        while (!(done || err) && n < 30000) begin @(negedge clk); n++; end
        if (n >= 30000) begin
            errs++; checks++;
            $display("FAIL %s watchdog: actual=timeout expected=finish", name);
        end
        chk({"R9/R10 done ", name}, int'(done), int'(ok));
        chk({"R10 err ", name}, int'(err), int'(!ok));
        chk({"R9 hv_en off ", name}, int'(hv_en), 0);
        chk({"R8 pulse count ", name}, pulses, ep);
        chk({"R11 verify count ", name}, verifies, ev);
        chk({"R6 first verify addr ", name}, first_ver, 0);
        if (ok) chk({"R9 restore writes ", name}, restores, 1);
        else begin
            chk({"R10 fail_addr ", name}, int'(fail_addr), ea);
            chk({"R10 no restore ", name}, restores, 0);
        end
    endtask

    initial begin
        int dummy, bad;
        dummy = $urandom(32'h5EED);
        for (int a = 0; a < NB; a++) need[a] = 1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk("R1 reset hv_en", int'(hv_en), 0);
        chk("R1 reset bus_req", int'(bus_req), 0);
        chk("R1 reset done/err", int'(done || err), 0);

        // R2: launch refused without pre-program flag
        @(posedge clk); #2 start = 1; preprog_ok = 0;
        @(posedge clk); #2 start = 0;
        bad = 0;
        repeat (20) begin @(negedge clk); if (hv_en || bus_req) bad++; end
        chk("R2 refused launch idle", bad, 0);

        run_case("single-pulse");
        repeat (10) @(negedge clk);
        chk("R12 done held", int'(done), 1);
        @(posedge clk); #2 start = 1; preprog_ok = 0;
        @(posedge clk); #2 start = 0;
        bad = 0;
        repeat (10) begin @(negedge clk); if (hv_en || bus_req || !done) bad++; end
        chk("R2 refused launch from done", bad, 0);

        for (int a = 0; a < NB; a++) need[a] = $urandom_range(1, 4);
        run_case("random-1to4");

        for (int a = 0; a < NB; a++) need[a] = $urandom_range(1, 3);
        need[NB-1] = MAXP;
        run_case("budget-edge-top");

        for (int a = 0; a < NB; a++) need[a] = $urandom_range(1, 2);
        need[5] = MAXP + 1; need[9] = MAXP + 2;
        run_case("budget-exceeded");
        chk("R12 err held", int'(err), 1);

        for (int k = 0; k < 3; k++) begin
            for (int a = 0; a < NB; a++) need[a] = $urandom_range(1, MAXP + 1);
            run_case("random-mixed");
        end

        errs += m_errs;
        checks += m_checks;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs + m_errs + 1, checks + m_checks + 1);
        $finish;
    end
endmodule